// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the clock for a memory-card bus from the system clock with a programmable integer ratio. It counts system-clock cycles and drives the card clock high for the first part of each output period and low for the rest. Alongside the clock it produces a one-cycle strobe in the system-clock domain that marks every rising card-clock edge. Logic that times command and data bits on the card bus can use this strobe without sampling the divided clock itself.

A static mode input selects how the ratio is formed. In the legacy mode the ratio is always even and is set by an 8-bit field. In the extended mode a 1-bit odd field becomes the least significant bit of a 9-bit divisor, with the 8-bit field as its upper part, so odd ratios are also possible. The configuration is captured only at the start of each output period, so reprogramming the block mid-period never shortens a pulse. An enable input parks the clock low.

Top module: `card_clk_div`

## Requirements
- R1: With `ext_mode`=0 the card clock period is 2*(`div_val`+1) system cycles, with equal high and low phases of `div_val`+1 cycles.
- R2: With `ext_mode`=1 the period is 2*`div_val`+`odd_val`+2 system cycles, where `odd_val` is bit 0 and `div_val` is bits 8:1 of a 9-bit divisor.
- R3: When the period is odd, the high phase lasts exactly one system cycle longer than the low phase.
- R4: The ratio spans from 2 (`div_val`=0, `odd_val`=0) up to 512 in legacy mode and 513 in extended mode (`div_val`=255).
- R5: A change to `div_val`, `odd_val` or `ext_mode` during a period has no effect on that period and applies from the next rising card-clock edge.
- R6: `card_rise` is high for exactly one system cycle, the first cycle in which `card_clk` is high after being low.
- R7: While `enable` is low, `card_clk` is low and `card_rise` is low from the next cycle on. On the first enabled clock edge the card clock rises and a new period starts with the current configuration.
- R8: During and right after reset, `card_clk` and `card_rise` are low and the period counter is at zero.
- R9: In legacy mode `odd_val` has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Divider field |
| odd_val | input | 1 | Half-step bit, used in extended mode only |
| ext_mode | input | 1 | 0 = legacy even-only ratio, 1 = extended ratio |
| enable | input | 1 | Runs the card clock when high |
| card_clk | output | 1 | Divided card clock |
| card_rise | output | 1 | One-cycle strobe on each rising card-clock edge |

## Verification
All outputs are registered. A rising edge, and its strobe, appears just after the first system edge that finds `enable` high or finds the counter at the end of a period. A stop appears just after the first edge that finds `enable` low. The driver changes inputs on falling edges. For every following rising edge it queues the expected pair of clock level and strobe, with the period and high length worked out from the configuration given at the start of that period. The monitor samples one time unit after each rising edge and compares it with the head of the queue, so each item is checked in exactly the cycle where it falls due. Mid-period reprogramming is checked the same way: the expected waveform keeps the captured configuration until the next period begins.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_EXT    = 1'b1
    } cbd_mode_e;

    // Width of a counter that holds the largest extended ratio for a divider field of width w
    function automatic int unsigned cnt_width(input int unsigned w);
        return w + 2;
    endfunction
endpackage

// File: rtl/cbd_ratio.sv
module cbd_ratio
    import cbd_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter bit          EXT_EN = 1'b1,
    localparam int unsigned CNT_W = cnt_width(DIV_W)
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             odd_val,
    input  logic             ext_mode,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] high_len
);
    logic [CNT_W-1:0] base;

    // base = div + 1, which is the high length for even ratios
    assign base = CNT_W'(div_val) + CNT_W'(1);

    generate
        if (EXT_EN) begin : g_ext
            logic use_odd;
            assign use_odd  = (cbd_mode_e'(ext_mode) == MODE_EXT) && odd_val;
            assign period   = (base << 1) + CNT_W'(use_odd);
            assign high_len = base + CNT_W'(use_odd);
        end else begin : g_legacy
            logic unused_in;
            assign unused_in = odd_val ^ ext_mode;
            assign period    = base << 1;
            assign high_len  = base;
        end
    endgenerate
endmodule

// File: rtl/cbd_phase_gen.sv
module cbd_phase_gen #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] high_in,
    output logic             card_clk,
    output logic             card_rise
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] hi;
        logic             run;
        logic             ck;
        logic             rise;
    } phase_t;

    phase_t st_d, st_q;
    logic   last_cyc;

    assign last_cyc = (st_q.cnt == st_q.per - CNT_W'(1));

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!enable) begin
            st_d.cnt = '0;
            st_d.run = 1'b0;
            st_d.ck  = 1'b0;
        end else if (!st_q.run || last_cyc) begin
            // period boundary: capture new ratio, raise the clock
            st_d.run  = 1'b1;
            st_d.cnt  = '0;
            st_d.per  = period_in;
            st_d.hi   = high_in;
            st_d.ck   = 1'b1;
            st_d.rise = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.ck  = (st_q.cnt + CNT_W'(1)) < st_q.hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.per <= CNT_W'(2);
            st_q.hi  <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk  = st_q.ck;
    assign card_rise = st_q.rise;

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        card_rise |-> (card_clk && !$past(card_clk)));                       // R6
    AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!card_clk && !card_rise));                              // R7
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt != '0) |-> (st_q.per == $past(st_q.per)));     // R5
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < st_q.per));                                 // R1
    AST_PHASE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> ((st_q.hi << 1) >= st_q.per && (st_q.hi << 1) <= st_q.per + CNT_W'(1))); // R3
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!card_clk && !card_rise && st_q.cnt == '0));             // R8
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import cbd_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter bit          EXT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             odd_val,
    input  logic             ext_mode,
    input  logic             enable,
    output logic             card_clk,
    output logic             card_rise
);
    localparam int unsigned CNT_W = cnt_width(DIV_W);

    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] high_w;

    cbd_ratio #(
        .DIV_W  (DIV_W),
        .EXT_EN (EXT_EN)
    ) u_ratio (
        .div_val  (div_val),
        .odd_val  (odd_val),
        .ext_mode (ext_mode),
        .period   (period_w),
        .high_len (high_w)
    );

    cbd_phase_gen #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .period_in (period_w),
        .high_in   (high_w),
        .card_clk  (card_clk),
        .card_rise (card_rise)
    );
endmodule

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] div_val;
    logic       odd_val;
    logic       ext_mode;
    logic       enable;
    logic       card_clk;
    logic       card_rise;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_div dut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .odd_val(odd_val),
        .ext_mode(ext_mode), .enable(enable), .card_clk(card_clk), .card_rise(card_rise)
    );

    task automatic push(input logic c, input logic r, input string t);
        exp_q.push_back({c, r});
        tag_q.push_back(t);
    endtask

    task automatic idle(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            enable = 1'b0;
            push(1'b0, 1'b0, t);
        end
    endtask

    // One output period: config applied at its first item; optional mid-period change and truncation
    task automatic run_period(input int d, input bit o, input bit m,
                              input int stop, input int chg_at, input int cd, input bit co,
                              input string t);
        int p;
        int h;
        p = m ? (2*d + int'(o) + 2) : 2*(d + 1);
        h = m ? (d + 1 + int'(o)) : (d + 1);
        for (int i = 0; i < p && (stop == 0 || i < stop); i++) begin
            @(negedge clk);
            if (i == 0) begin
                enable = 1'b1; div_val = 8'(d); odd_val = o; ext_mode = m;
            end
            if (i != 0 && i == chg_at) begin
                div_val = 8'(cd); odd_val = co;
            end
            push(i < h, i == 0, t);
        end
    endtask

    // Monitor: compares one queued item per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({card_clk, card_rise} !== e) begin
                    n_fail++;
                    $display("FAIL %s: clk/rise actual %b expected %b at %0t", t,
                             {card_clk, card_rise}, e, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; div_val = 8'd0; odd_val = 1'b0; ext_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (card_clk !== 1'b0 || card_rise !== 1'b0) begin
                n_fail++;
                $display("FAIL R8 reset: actual %b%b expected 00", card_clk, card_rise);
            end
        end
        @(negedge clk);
        enable = 1'b0;
        rst_n  = 1'b1;
        idle(2, "R8 after reset");

        for (int k = 0; k < 3; k++) run_period(0, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R1 legacy div0");
        for (int k = 0; k < 2; k++) run_period(3, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R9 legacy odd ignored");
        for (int k = 0; k < 2; k++) run_period(3, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R3 ext ratio 9");
        for (int k = 0; k < 2; k++) run_period(2, 1'b0, 1'b1, 0, 0, 0, 1'b0, "R2 ext ratio 6");
        for (int k = 0; k < 3; k++) run_period(0, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R3 ext ratio 3");
        for (int k = 0; k < 2; k++) run_period(0, 1'b0, 1'b1, 0, 0, 0, 1'b0, "R4 ext ratio 2");
        run_period(255, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R4 legacy ratio 512");
        run_period(255, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R4 ext ratio 513");
        run_period(4, 1'b1, 1'b1, 0, 3, 0, 1'b0, "R5 change mid period");
        run_period(4, 1'b0, 1'b1, 0, 6, 1, 1'b1, "R5 change late in period");
        run_period(1, 1'b0, 1'b1, 0, 0, 0, 1'b0, "R5 new ratio at boundary");
        run_period(5, 1'b0, 1'b1, 4, 0, 0, 1'b0, "R7 before stop");
        idle(3, "R7 stopped");
        for (int k = 0; k < 2; k++) run_period(1, 1'b1, 1'b1, 0, 0, 0, 1'b0, "R6 restart");
        idle(2, "R7 final stop");

        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule